// File: doc/BRIEF.md
# Mixed-decay current chopping controller

This block is the per-phase sequencer for sensorless constant-current chopping of one motor winding. It divides a free-running chopping oscillator into periods of sixteen ticks. At the start of each period it drives the bridge into charge. It then moves to fast decay once the regulation comparator trips. It falls to slow decay when the current drops below a second, lower decay-selection threshold. The result is fast-only, slow-after-fast (mixed) or charge-only behaviour within a period.

Two events override the normal period flow. When the current set-point steps down, a one-cycle notice starts a short charge probe. At the end of the probe the regulation comparator is sampled. If the current is already above the new threshold, the bridge goes straight to fast decay. Right after charge begins, the regulation comparator is masked for a programmable number of clock cycles so that the inrush spike is not taken for a threshold crossing. A low enable input turns the bridge off until a later period boundary.

The comparators, the current measurement and the gate drivers sit outside. The block only reports which bridge mode applies. It does so as three one-hot drive lines and as a 2-bit code.

Top module: `chop_mixed_decay_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the bridge in off (mode code 0, all drive lines low) and clears the period tick counter, so the next period boundary needs a full sixteen fresh ticks.
- R2: A period boundary occurs on the clock edge that samples the sixteenth `osc_tick` since the previous boundary (or since reset). Clock cycles without a tick do not advance the period. From off, the bridge turns to charge only at a period boundary.
- R3: On entering charge, `cmp_reg_hi` is ignored on the first BLANK_CYC clock edges. On any later edge in charge, a high `cmp_reg_hi` turns the bridge to fast decay on that edge.
- R4: Fast decay persists while `cmp_mix_hi` is high. A low `cmp_mix_hi` turns it to slow decay. Slow decay ignores both comparators and never returns to fast within the period.
- R5: A period boundary in fast or slow decay turns the bridge to charge, with blanking restarted.
- R6: A period boundary that finds the bridge still in charge keeps it in charge, without restarting the blanking window.
- R7: A `setpoint_drop` pulse while enabled and not off starts a probe. The probe reports charge for exactly PROBE_CYC cycles, ignores period boundaries, and samples `cmp_reg_hi` on its last edge. A high sample turns the bridge to fast decay.
- R8: A probe that samples `cmp_reg_hi` low continues as ordinary charge with a fresh full blanking window.
- R9: A low `enable` turns the bridge off on the next edge. While off, `setpoint_drop` and the comparators have no effect. After `enable` returns high, charge resumes only at the next period boundary.
- R10: `mode_code` encodes 0 = off, 1 = charge (probe included), 2 = fast decay, 3 = slow decay. Exactly the matching one of `drv_charge`, `drv_fast`, `drv_slow` is high, and none of them is high when off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High allows bridge drive; low forces off |
| osc_tick | input | 1 | One chopping-oscillator tick per high cycle |
| cmp_reg_hi | input | 1 | Winding current above regulation threshold |
| cmp_mix_hi | input | 1 | Winding current above decay-selection threshold |
| setpoint_drop | input | 1 | One-cycle notice that the set-point just decreased |
| drv_charge | output | 1 | Bridge in charge |
| drv_fast | output | 1 | Bridge in fast decay |
| drv_slow | output | 1 | Bridge in slow decay |
| mode_code | output | 2 | Current mode: 0 off, 1 charge, 2 fast, 3 slow |

## Verification
The regulation comparator is held high from the first cycle of charge, so an early fast-decay entry would expose a short or missing blanking window. The decay-selection comparator is dropped part-way through fast decay and then raised again in slow decay, which separates a correct one-way fast-to-slow path from one that re-evaluates. Set-point drops are applied once with the current above and once with it below the new threshold, which tells the immediate fast-decay exit from the probe-then-blanked-charge path. Period boundaries are placed in off, charge, fast and slow states, and after a mid-period reset, to show which states restart blanking and that the tick count restarts.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_CHARGE = 3'd1,
        ST_PROBE  = 3'd2,
        ST_FAST   = 3'd3,
        ST_SLOW   = 3'd4
    } chop_state_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHARGE = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_SLOW   = 2'd3
    } bridge_mode_e;

    localparam int unsigned DRIVE_LANES = 3;

    function automatic bridge_mode_e mode_of(chop_state_e s);
        case (s)
            ST_CHARGE, ST_PROBE: return MODE_CHARGE;
            ST_FAST:             return MODE_FAST;
            ST_SLOW:             return MODE_SLOW;
            default:             return MODE_OFF;
        endcase
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    output logic period_start
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] phase;

    assign period_start = osc_tick && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (osc_tick) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/chop_dwell_counter.sv
module chop_dwell_counter #(
    parameter int unsigned MAXV = 156,
    localparam int unsigned W = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CEIL = W'(MAXV);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run && (count != CEIL)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
    import chop_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 156,
    parameter int unsigned PROBE_CYC = 24,
    parameter int unsigned W         = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         setpoint_drop,
    input  logic         cmp_reg_hi,
    input  logic         cmp_mix_hi,
    input  logic         period_start,
    input  logic [W-1:0] dwell,
    output chop_state_e  state,
    output logic         dwell_clear,
    output logic         dwell_run
);
    localparam logic [W-1:0] BLANK_END  = W'(BLANK_CYC);
    localparam logic [W-1:0] PROBE_LAST = W'(PROBE_CYC - 1);

    chop_state_e nxt;

    assign dwell_run = (state == ST_CHARGE) || (state == ST_PROBE);

    always_comb begin
        nxt         = state;
        dwell_clear = 1'b0;
        if (!enable) begin
            nxt = ST_OFF;
        end else if (setpoint_drop && (state != ST_OFF)) begin
            nxt         = ST_PROBE;
            dwell_clear = 1'b1;
        end else begin
            case (state)
                ST_OFF: begin
                    if (period_start) begin
                        nxt         = ST_CHARGE;
                        dwell_clear = 1'b1;
                    end
                end
                ST_PROBE: begin
                    if (dwell == PROBE_LAST) begin
                        if (cmp_reg_hi) begin
                            nxt = ST_FAST;
                        end else begin
                            nxt         = ST_CHARGE;
                            dwell_clear = 1'b1;
                        end
                    end
                end
                ST_CHARGE: begin
                    if (!period_start && (dwell >= BLANK_END) && cmp_reg_hi) begin
                        nxt = ST_FAST;
                    end
                end
                ST_FAST: begin
                    if (period_start) begin
                        nxt         = ST_CHARGE;
                        dwell_clear = 1'b1;
                    end else if (!cmp_mix_hi) begin
                        nxt = ST_SLOW;
                    end
                end
                ST_SLOW: begin
                    if (period_start) begin
                        nxt         = ST_CHARGE;
                        dwell_clear = 1'b1;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/chop_drive_decode.sv
module chop_drive_decode
    import chop_pkg::*;
(
    input  chop_state_e state,
    output logic [1:0]  mode_code,
    output logic        drv_charge,
    output logic        drv_fast,
    output logic        drv_slow
);
    bridge_mode_e              mode;
    logic [DRIVE_LANES-1:0]    lane;

    assign mode      = mode_of(state);
    assign mode_code = mode;

    for (genvar i = 0; i < DRIVE_LANES; i++) begin : g_lane
        assign lane[i] = (mode == bridge_mode_e'(i + 1));
    end

    assign drv_charge = lane[0];
    assign drv_fast   = lane[1];
    assign drv_slow   = lane[2];
endmodule

// File: rtl/chop_mixed_decay_ctrl.sv
module chop_mixed_decay_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 16,
    parameter int unsigned BLANK_CYC    = 156,
    parameter int unsigned PROBE_CYC    = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       osc_tick,
    input  logic       cmp_reg_hi,
    input  logic       cmp_mix_hi,
    input  logic       setpoint_drop,
    output logic       drv_charge,
    output logic       drv_fast,
    output logic       drv_slow,
    output logic [1:0] mode_code
);
    localparam int unsigned DWELL_MAX = max_of(BLANK_CYC, PROBE_CYC);
    localparam int unsigned DWELL_W   = $clog2(DWELL_MAX + 1);

    logic               period_start;
    logic               dwell_clear;
    logic               dwell_run;
    logic [DWELL_W-1:0] dwell_cnt;
    chop_state_e        st;

    chop_period_timer #(.TICKS(PERIOD_TICKS)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .osc_tick     (osc_tick),
        .period_start (period_start)
    );

    chop_dwell_counter #(.MAXV(DWELL_MAX)) u_dwell (
        .clk   (clk),
        .rst   (rst),
        .clear (dwell_clear),
        .run   (dwell_run),
        .count (dwell_cnt)
    );

    chop_sequencer #(
        .BLANK_CYC (BLANK_CYC),
        .PROBE_CYC (PROBE_CYC),
        .W         (DWELL_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .setpoint_drop (setpoint_drop),
        .cmp_reg_hi    (cmp_reg_hi),
        .cmp_mix_hi    (cmp_mix_hi),
        .period_start  (period_start),
        .dwell         (dwell_cnt),
        .state         (st),
        .dwell_clear   (dwell_clear),
        .dwell_run     (dwell_run)
    );

    chop_drive_decode u_dec (
        .state      (st),
        .mode_code  (mode_code),
        .drv_charge (drv_charge),
        .drv_fast   (drv_fast),
        .drv_slow   (drv_slow)
    );
endmodule

// File: rtl/chop_mixed_decay_chk.sv
module chop_mixed_decay_chk
    import chop_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 156,
    parameter int unsigned DW        = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic          setpoint_drop,
    input logic          period_start,
    input logic [DW-1:0] dwell,
    input chop_state_e   state,
    input logic [1:0]    mode_code,
    input logic          drv_charge,
    input logic          drv_fast,
    input logic          drv_slow
);
    localparam logic [DW-1:0] BLANK_END = DW'(BLANK_CYC);

    // R10: drive lines never overlap and agree with the code
    a_r10_onehot_drive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drv_charge, drv_fast, drv_slow}));
    a_r10_fast_code: assert property (@(posedge clk) disable iff (rst)
        drv_fast |-> (mode_code == 2'd2));

    // R9: disable forces off on the next edge
    a_r9_disable_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (mode_code == 2'd0));

    // R2: off is left only at a period boundary
    a_r2_off_wait: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'd0 && !period_start) |=> (mode_code == 2'd0));

    // R3: no fast decay while the blanking window is open
    a_r3_blank_mask: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHARGE && dwell < BLANK_END && enable && !setpoint_drop)
        |=> (state != ST_FAST));

    // R4: slow decay holds until a period boundary
    a_r4_slow_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOW && enable && !setpoint_drop && !period_start)
        |=> (state == ST_SLOW));

    // R5: a boundary in a decay state restarts charge with fresh blanking
    a_r5_decay_restart: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FAST || state == ST_SLOW) && period_start && enable && !setpoint_drop)
        |=> (state == ST_CHARGE && dwell == '0));

    // R6: a boundary during charge keeps charge
    a_r6_charge_keep: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHARGE && period_start && enable && !setpoint_drop)
        |=> (state == ST_CHARGE));

    // R7: a set-point drop while active starts the probe
    a_r7_probe_entry: assert property (@(posedge clk) disable iff (rst)
        (enable && setpoint_drop && mode_code != 2'd0) |=> (state == ST_PROBE));
endmodule

bind chop_mixed_decay_ctrl chop_mixed_decay_chk #(
    .BLANK_CYC (BLANK_CYC),
    .DW        (DWELL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .setpoint_drop (setpoint_drop),
    .period_start  (period_start),
    .dwell         (dwell_cnt),
    .state         (st),
    .mode_code     (mode_code),
    .drv_charge    (drv_charge),
    .drv_fast      (drv_fast),
    .drv_slow      (drv_slow)
);

// File: tb/chop_mixed_decay_ctrl_bench.sv
module chop_mixed_decay_ctrl_bench;

    localparam int unsigned BLANK = 4;
    localparam int unsigned PROBE = 3;
    localparam int NV = 24;

    typedef struct packed {
        logic [4:0] n;
        logic       en;
        logic       sp;
        logic       cr;
        logic       cm;
        logic       tk;
        logic [1:0] ex;
        logic [3:0] req;
    } vec_t;

    // fields: cycles, enable, setpoint_drop, cmp_reg_hi, cmp_mix_hi, osc_tick, expected mode, requirement
    localparam vec_t VEC [NV] = '{
        '{5'd15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 4'd2},  // R2: 15 ticks, still off
        '{5'd1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 4'd2},  // R2: 16th tick starts charge
        '{5'd4,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 4'd3},  // R3: masked edges
        '{5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd3},  // R3: first honoured edge
        '{5'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd4},  // R4: fast holds
        '{5'd1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd4},  // R4: fall to slow
        '{5'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 4'd4},  // R4: slow ignores comparators
        '{5'd16, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 4'd5},  // R5: boundary from slow
        '{5'd16, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 4'd6},  // R6: whole period in charge
        '{5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd6},  // R6: blanking not restarted
        '{5'd1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'd7},  // R7: probe entry from fast
        '{5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 4'd7},  // R7: probe still charging
        '{5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd7},  // R7: probe end, above -> fast
        '{5'd1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd8},  // R8: probe entry
        '{5'd3,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd8},  // R8: probe end, below -> charge
        '{5'd4,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 4'd8},  // R8: fresh blanking
        '{5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd8},  // R8: after blanking -> fast
        '{5'd1,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'd9},  // R9: disable
        '{5'd2,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd9},  // R9: drop while disabled
        '{5'd1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd9},  // R9: drop while off, enabled
        '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'd9},  // R9: waits for boundary
        '{5'd16, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 4'd9},  // R9: resumes at boundary
        '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 4'd3},  // R3: blank then fast
        '{5'd16, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 4'd5}   // R5: boundary from fast
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       osc_tick = 1'b0;
    logic       cmp_reg_hi = 1'b0;
    logic       cmp_mix_hi = 1'b0;
    logic       setpoint_drop = 1'b0;
    logic       drv_charge, drv_fast, drv_slow;
    logic [1:0] mode_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    chop_mixed_decay_ctrl #(
        .PERIOD_TICKS (16),
        .BLANK_CYC    (BLANK),
        .PROBE_CYC    (PROBE)
    ) u_chop_mixed_decay_ctrl (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .osc_tick      (osc_tick),
        .cmp_reg_hi    (cmp_reg_hi),
        .cmp_mix_hi    (cmp_mix_hi),
        .setpoint_drop (setpoint_drop),
        .drv_charge    (drv_charge),
        .drv_fast      (drv_fast),
        .drv_slow      (drv_slow),
        .mode_code     (mode_code)
    );

    // R10: every check compares the code and all three drive lines
    task automatic check(input logic [1:0] ex, input int req, input int step);
        logic [4:0] got;
        logic [4:0] want;
        got  = {mode_code, drv_charge, drv_fast, drv_slow};
        want = {ex, ex == 2'd1, ex == 2'd2, ex == 2'd3};
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL R%0d step %0d: mode=%0d drv=%b, expected mode=%0d drv=%b",
                     req, step, got[4:3], got[2:0], want[4:3], want[2:0]);
        end
    endtask

    task automatic drive(input logic en, input logic sp, input logic cr,
                         input logic cm, input logic tk, input int n);
        @(negedge clk);
        enable = en; setpoint_drop = sp; cmp_reg_hi = cr; cmp_mix_hi = cm; osc_tick = tk;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(2'd0, 1, -1);  // R1: reset state is off

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].en, VEC[i].sp, VEC[i].cr, VEC[i].cm, VEC[i].tk, int'(VEC[i].n));
            check(VEC[i].ex, int'(VEC[i].req), i);
        end

        // R1: reset mid-period clears the tick counter
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5);
        check(2'd1, 1, 100);
        @(negedge clk);
        rst = 1'b1; osc_tick = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(2'd0, 1, 101);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 15);
        check(2'd0, 1, 102);   // R1: 15 fresh ticks, no boundary yet
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1);
        check(2'd1, 2, 103);   // R2: 16th tick after reset

        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule